// File: doc/BRIEF.md
# Non-Pipelined Execution Unit Issue Controller

This block decides, cycle by cycle, whether the instruction sitting in the decode stage may move into execute. Four execution units hang off the pipeline: an integer unit, a multiplier, a floating-point adder and a divider. The integer unit takes loads, stores, integer ALU operations and branches. The multiplier takes both integer and floating-point multiplies. The adder takes add, subtract and format conversion. The divider takes both integer and floating-point divides. The decoder tells the block which unit the instruction needs.

None of the units is pipelined. An instruction that enters a unit holds it for that unit's full execute length, and the length differs from unit to unit. While the needed unit is still held, the block raises a stall. The stall freezes decode and every earlier stage. Instructions bound for different units may run side by side. Each unit gives a one-cycle completion pulse in its final execute cycle. In that same cycle the unit accepts the next instruction, which enters execute on the following cycle.

Top module: `fu_issue_ctrl`

## Requirements
- R1: While `rst` is high (synchronous, active high), `issue`, `stall` and every bit of `unit_done` are 0. At the first cycle after reset is released, every unit is idle.
- R2: When `dec_valid` is 1 and the selected unit is idle or in its final execute cycle, `issue` is 1 in that same cycle and `stall` is 0.
- R3: `issue` and `stall` are never 1 in the same cycle.
- R4: An instruction issued in cycle t to a unit with execute length L gives exactly one `unit_done` pulse for that unit, in cycle t+L. Bit k of `unit_done` belongs to the unit with code k.
- R5: A unit that accepted an instruction in cycle t rejects new requests for itself in cycles t+1 to t+L-1. In those cycles `stall` is 1 and `issue` is 0. The unit accepts a new request in cycle t+L.
- R6: Units run independently. A unit that is held never delays or stalls a request for a different, free unit, and several units may be in execute at once.
- R7: When `dec_valid` is 0, `issue` and `stall` are 0, and no unit is started.
- R8: `dec_unit` encoding: 0 selects the integer unit, 1 the multiplier, 2 the floating-point adder, 3 the divider.
- R9: The execute lengths are parameters. Their defaults are 1 for the integer unit, 7 for the multiplier, 4 for the adder and 24 for the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode stage holds an instruction wanting to issue |
| dec_unit | input | 2 | Execution unit the decoded instruction needs (encoding in R8) |
| issue | output | 1 | Instruction moves from decode into execute this cycle |
| stall | output | 1 | Decode and earlier stages must hold this cycle |
| unit_done | output | 4 | Per-unit pulse in the final execute cycle |

## Verification
The bench issues to each unit and then probes that same unit again at every distance from 1 to L+1 cycles later. A design that frees a unit one cycle early lets a second instruction into a unit that is still busy. A design that frees it one cycle late puts a bubble after every divide or multiply, and for the one-cycle integer unit it halves throughput. The completion pulse is checked at every distance, which catches an off-by-one countdown and also a pulse that repeats or never appears. Long stretches of mixed traffic across all four units check that a held divider never stalls a multiply or an integer operation. In these stretches, a request in the final cycle of the divider must restart it with no gap.

// File: rtl/fu_issue_pkg.sv
package fu_issue_pkg;

    localparam int FU_COUNT = 4;

    // Unit selector codes; the numeric value indexes unit_done (R8)
    typedef enum logic [1:0] {
        FU_INT  = 2'd0,
        FU_MUL  = 2'd1,
        FU_FADD = 2'd2,
        FU_DIV  = 2'd3
    } fu_sel_e;

    typedef logic [FU_COUNT-1:0] fu_vec_t;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fu_occupancy_timer.sv
module fu_occupancy_timer #(
    parameter int CYCLES = 4,
    parameter int CW     = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic held,
    output logic last
);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    // Held until the final execute cycle; the final cycle may accept a new start
    assign held = (remain > CW'(1));
    assign last = (remain == CW'(1)) && !rst;

    // R4: one pulse per occupancy unless immediately restarted
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (last && !start) |=> !last);

    // R5: a held unit stays held or reaches its final cycle
    a_r5_hold_until_last: assert property (@(posedge clk) disable iff (rst)
        held |=> (held || last));

    // R5: a start is only ever granted to a unit that is not held
    a_r5_no_start_while_held: assert property (@(posedge clk) disable iff (rst)
        start |-> !held);

endmodule

// File: rtl/fu_issue_gate.sv
module fu_issue_gate
    import fu_issue_pkg::*;
(
    input  logic    enable,
    input  logic    dec_valid,
    input  fu_sel_e dec_unit,
    input  fu_vec_t held,
    output logic    issue,
    output logic    stall,
    output fu_vec_t start
);

    logic want;
    logic blocked;

    assign want    = enable && dec_valid;
    assign blocked = held[dec_unit];

    assign issue = want && !blocked;
    assign stall = want && blocked;

    always_comb begin
        start = '0;
        if (issue) start[dec_unit] = 1'b1;
    end

endmodule

// File: rtl/fu_issue_ctrl.sv
module fu_issue_ctrl
    import fu_issue_pkg::*;
#(
    parameter int INT_CYCLES  = 1,
    parameter int MUL_CYCLES  = 7,
    parameter int FADD_CYCLES = 4,
    parameter int DIV_CYCLES  = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dec_valid,
    input  logic [1:0] dec_unit,
    output logic       issue,
    output logic       stall,
    output logic [3:0] unit_done
);

    localparam int MAX_CYCLES = max_of4(INT_CYCLES, MUL_CYCLES, FADD_CYCLES, DIV_CYCLES);
    localparam int CW         = $clog2(MAX_CYCLES + 1);
    localparam int UNIT_CYCLES [FU_COUNT] = '{INT_CYCLES, MUL_CYCLES, FADD_CYCLES, DIV_CYCLES};

    fu_vec_t held;
    fu_vec_t last;
    fu_vec_t start;

    fu_issue_gate u_gate (
        .enable    (!rst),
        .dec_valid (dec_valid),
        .dec_unit  (fu_sel_e'(dec_unit)),
        .held      (held),
        .issue     (issue),
        .stall     (stall),
        .start     (start)
    );

    for (genvar k = 0; k < FU_COUNT; k++) begin : g_unit
        fu_occupancy_timer #(
            .CYCLES (UNIT_CYCLES[k]),
            .CW     (CW)
        ) u_timer (
            .clk   (clk),
            .rst   (rst),
            .start (start[k]),
            .held  (held[k]),
            .last  (last[k])
        );
    end

    assign unit_done = last;

    // R1: quiet outputs during reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |-> (!issue && !stall && unit_done == 4'b0));

    // R3: issue and stall are mutually exclusive
    a_r3_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(issue && stall));

    // R7: nothing happens without a valid request
    a_r7_idle_request: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> (!issue && !stall));

    // R2: a valid request that is not stalled issues
    a_r2_issue_when_free: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !stall) |-> issue);

    // R6: at most one unit starts per cycle
    a_r6_one_start: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start));

endmodule

// File: tb/fu_issue_ctrl_tb.sv
module fu_issue_ctrl_tb;

    localparam int LAT [4] = '{1, 7, 4, 24};   // R9 default lengths

    logic       clk = 1'b0;
    logic       rst;
    logic       dec_valid;
    logic [1:0] dec_unit;
    logic       issue;
    logic       stall;
    logic [3:0] unit_done;

    int cyc;
    int n_vec;
    int n_bad;
    int iss_at [4];

    always #4 clk = ~clk;   // 125 MHz

    fu_issue_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .dec_valid (dec_valid),
        .dec_unit  (dec_unit),
        .issue     (issue),
        .stall     (stall),
        .unit_done (unit_done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // One cycle: drive at negedge, check before posedge, update model, advance
    task automatic step(input bit v, input int u, input string req_issue);
        logic [3:0] e_done;
        logic [3:0] e_held;
        bit e_issue;
        bit e_stall;
        dec_valid = v;
        dec_unit  = u[1:0];          // R8 encoding: code = unit index
        #1;
        for (int k = 0; k < 4; k++) begin
            e_held[k] = (cyc > iss_at[k]) && (cyc < iss_at[k] + LAT[k]);
            e_done[k] = (cyc == iss_at[k] + LAT[k]);
        end
        e_issue = v && !e_held[u];
        e_stall = v && e_held[u];
        chk(v ? req_issue : "R7", "issue", int'(issue), int'(e_issue));
        chk(v ? "R5" : "R7", "stall", int'(stall), int'(e_stall));
        chk("R4 R9", "unit_done", int'(unit_done), int'(e_done));
        chk("R3", "issue&stall", int'(issue && stall), 0);
        if (e_issue) iss_at[u] = cyc;
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        n_vec = 0;
        n_bad = 0;
        cyc   = 0;
        for (int k = 0; k < 4; k++) iss_at[k] = -1000;
        rst       = 1'b1;
        dec_valid = 1'b0;
        dec_unit  = 2'd0;
        @(negedge clk);
        // R1: requests during reset produce nothing
        for (int i = 0; i < 4; i++) begin
            dec_valid = 1'b1;
            dec_unit  = 2'(i);
            #1;
            chk("R1", "issue in reset", int'(issue), 0);
            chk("R1", "stall in reset", int'(stall), 0);
            chk("R1", "unit_done in reset", int'(unit_done), 0);
            @(posedge clk);
            @(negedge clk);
        end
        rst = 1'b0;
        cyc = 0;

        // R5 / R4: probe every unit again at every distance 1..L+1
        for (int u = 0; u < 4; u++) begin
            for (int d = 1; d <= LAT[u] + 1; d++) begin
                step(1'b1, u, "R2");
                for (int g = 1; g < d; g++) step(1'b0, 0, "R7");
                step(1'b1, u, "R2");
                for (int g = 0; g < LAT[u] + 2; g++) step(1'b0, 0, "R7");
            end
        end

        // R6: all units in flight together, then back-to-back into busy ones
        step(1'b1, 3, "R6");
        step(1'b1, 1, "R6");
        step(1'b1, 2, "R6");
        step(1'b1, 0, "R6");
        step(1'b1, 0, "R6");
        step(1'b1, 3, "R6");
        for (int g = 0; g < 30; g++) step(1'b0, 0, "R7");

        // R6: mixed traffic
        for (int i = 0; i < 4000; i++) begin
            bit v;
            int u;
            v = ($urandom % 4) != 0;
            u = int'($urandom % 4);
            step(v, u, "R6");
        end
        for (int g = 0; g < 30; g++) step(1'b0, 0, "R7");

        summary();
        $finish;
    end

endmodule